// File: doc/BRIEF.md
# Bounded Hardware Stack Pointer Unit

This unit owns the stack pointer of a 16-bit processor whose data memory is addressed in bytes. The stack grows toward higher addresses, and the pointer always names the next free word. A push writes at the pointer and then advances it by two. A pop first steps back by two and then reads. Every address formed through the pointer is checked against two bounds: a fixed floor that keeps the stack out of the special-function register region, and an upper bound that software programs. When an address breaks either bound, the unit raises a stack error trap.

The unit also builds call frames from a 23-bit program counter. A frame is two words written in two consecutive cycles: the low sixteen PC bits first, then the top seven PC bits. For a plain call the rest of the second word is zero. For exception entry the status byte sits in the upper byte of the second word. The data RAM port, the trap pulse and the pointer value are all registered, so each appears one clock after the request that caused it. Instruction decode, trap vectoring and the RAM are outside the unit.

Top module: `stkptr_unit`

## Requirements
- R1: After reset the pointer reads 0x0800. trap, busy, mem_we and mem_re are low, and the upper-bound check is off.
- R2: A push request writes push_data to the current pointer address and adds 2 to the pointer. The write and the new pointer are visible one clock after the request.
- R3: A pop request reads from pointer minus 2 and leaves the pointer at that address. The read strobe and the new pointer are visible one clock after the request.
- R4: Bit 0 of a value written to the upper bound is discarded, and the pointer is always even.
- R5: An access whose address is greater than the stored upper bound traps. An access whose address equals the bound is accepted.
- R6: An access whose address is below 0x0800 traps; a pop with the pointer at 0x0800 is one such access.
- R7: A trap is a registered pulse, one for each offending request. The offending write or read is dropped and the pointer is unchanged.
- R8: A bound write takes effect late. An access in the same cycle as the write, or in the cycle right after it, is checked against the previous bound. From the second cycle after the write, the new bound applies.
- R9: A call request writes pc[15:0] at the pointer, then {9'b0, pc[22:16]} at the pointer plus 2 in the next cycle. The pointer ends 4 higher. busy is high while the second word is pending, and requests presented in that cycle are ignored.
- R10: An exception request builds the same frame, except that the second word is {status[7:0], 1'b0, pc[22:16]}.
- R11: When several requests arrive in one cycle, the order of precedence is exception, call, push, pop.
- R12: Until the upper bound has been written once after reset, only the floor is checked.
- R13: If the first frame word traps, nothing more is written and busy stays low. If the second word traps, the first word stays written and the pointer ends 2 higher.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_req | input | 1 | Push one word |
| pop_req | input | 1 | Pop one word |
| call_req | input | 1 | Build a call frame |
| exc_req | input | 1 | Build an exception frame |
| push_data | input | 16 | Word to push |
| pc_in | input | 23 | Program counter for frames |
| status_in | input | 8 | Status byte for exception frames |
| lim_we | input | 1 | Write the upper bound |
| lim_wdata | input | 16 | New upper bound |
| mem_we | output | 1 | RAM write strobe |
| mem_re | output | 1 | RAM read strobe |
| mem_addr | output | 16 | RAM byte address |
| mem_wdata | output | 16 | RAM write data |
| sp_out | output | 16 | Current stack pointer |
| busy | output | 1 | Second frame word pending |
| trap | output | 1 | Stack error pulse |

## Verification
The bench builds the unit with its default parameters. With the reset pointer equal to the floor, a single pop from reset reaches the underflow case. Bounds programmed a few words above 0x0800 make the at-bound push, the first over-bound push and a frame whose second word crosses the bound reachable in a handful of cycles. A randomized stretch mixes simultaneous requests, bound rewrites and requests issued while busy, all compared against a behavioural model.

// File: rtl/stk_pkg.sv
package stk_pkg;
    typedef enum logic [2:0] {
        OP_NONE,
        OP_PUSH,
        OP_POP,
        OP_CALL,
        OP_EXC,
        OP_UPPER
    } stk_op_e;
endpackage

// File: rtl/stk_bound_chk.sv
module stk_bound_chk #(
    parameter int DW    = 16,
    parameter int FLOOR = 16'h0800
) (
    input  logic [DW-1:0] addr,
    input  logic [DW-1:0] lim,
    input  logic          lim_on,
    output logic          bad
);
    localparam logic [DW-1:0] FLOOR_V = DW'(FLOOR);

    logic below, above;

    always_comb begin
        below = (addr < FLOOR_V);
        above = lim_on && (addr > lim);
        bad   = below || above;
    end
endmodule

// File: rtl/stk_frame_fmt.sv
module stk_frame_fmt #(
    parameter int DW   = 16,
    parameter int PC_W = 23,
    parameter int ST_W = 8
) (
    input  logic [PC_W-1:0] pc,
    input  logic [ST_W-1:0] status,
    input  logic            with_status,
    output logic [DW-1:0]   lo_word,
    output logic [DW-1:0]   hi_word
);
    localparam int HI_W = PC_W - DW;

    always_comb begin
        lo_word = pc[DW-1:0];
        hi_word = '0;
        hi_word[HI_W-1:0] = pc[PC_W-1:DW];
        if (with_status) begin
            hi_word[DW-1 -: ST_W] = status;
        end
    end
endmodule

// File: rtl/stkptr_unit.sv
module stkptr_unit #(
    parameter int DW       = 16,
    parameter int PC_W     = 23,
    parameter int ST_W     = 8,
    parameter int FLOOR    = 16'h0800,
    parameter int SP_RESET = 16'h0800
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_req,
    input  logic            pop_req,
    input  logic            call_req,
    input  logic            exc_req,
    input  logic [DW-1:0]   push_data,
    input  logic [PC_W-1:0] pc_in,
    input  logic [ST_W-1:0] status_in,
    input  logic            lim_we,
    input  logic [DW-1:0]   lim_wdata,
    output logic            mem_we,
    output logic            mem_re,
    output logic [DW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic [DW-1:0]   sp_out,
    output logic            busy,
    output logic            trap
);
    import stk_pkg::*;

    localparam logic [DW-1:0] STEP    = DW'(2);
    localparam logic [DW-1:0] ALIGN_M = ~DW'(1);

    typedef struct packed {
        logic [DW-1:0] sp;
        logic [DW-1:0] lim;
        logic [DW-1:0] lim_stage;
        logic          lim_on;
        logic          stage_v;
        logic          phase;
        logic [DW-1:0] upper;
        logic          we;
        logic          re;
        logic          trap;
        logic [DW-1:0] addr;
        logic [DW-1:0] wdata;
    } state_t;

    state_t q, d;

    stk_op_e       op;
    logic [DW-1:0] acc_addr;
    logic          acc_bad;
    logic [DW-1:0] frame_lo, frame_hi;

    // request selection: pending upper word, then exception, call, push, pop
    always_comb begin
        if (q.phase)       op = OP_UPPER;
        else if (exc_req)  op = OP_EXC;
        else if (call_req) op = OP_CALL;
        else if (push_req) op = OP_PUSH;
        else if (pop_req)  op = OP_POP;
        else               op = OP_NONE;
        acc_addr = (op == OP_POP) ? (q.sp - STEP) : q.sp;
    end

    stk_bound_chk #(.DW(DW), .FLOOR(FLOOR)) u_bound (
        .addr   (acc_addr),
        .lim    (q.lim),
        .lim_on (q.lim_on),
        .bad    (acc_bad)
    );

    stk_frame_fmt #(.DW(DW), .PC_W(PC_W), .ST_W(ST_W)) u_frame (
        .pc          (pc_in),
        .status      (status_in),
        .with_status (op == OP_EXC),
        .lo_word     (frame_lo),
        .hi_word     (frame_hi)
    );

    always_comb begin
        d       = q;
        d.we    = 1'b0;
        d.re    = 1'b0;
        d.trap  = 1'b0;
        d.addr  = '0;
        d.wdata = '0;
        d.phase = 1'b0;

        if (op != OP_NONE) begin
            if (acc_bad) begin
                d.trap = 1'b1;
            end else begin
                d.addr = acc_addr;
                unique case (op)
                    OP_PUSH: begin
                        d.we    = 1'b1;
                        d.wdata = push_data;
                        d.sp    = q.sp + STEP;
                    end
                    OP_POP: begin
                        d.re = 1'b1;
                        d.sp = acc_addr;
                    end
                    OP_CALL, OP_EXC: begin
                        d.we    = 1'b1;
                        d.wdata = frame_lo;
                        d.sp    = q.sp + STEP;
                        d.phase = 1'b1;
                        d.upper = frame_hi;
                    end
                    OP_UPPER: begin
                        d.we    = 1'b1;
                        d.wdata = q.upper;
                        d.sp    = q.sp + STEP;
                    end
                    default: ;
                endcase
            end
        end

        // bound update lands one cycle after the staging register
        if (q.stage_v) begin
            d.lim     = q.lim_stage;
            d.lim_on  = 1'b1;
            d.stage_v = 1'b0;
        end
        if (lim_we) begin
            d.lim_stage = lim_wdata & ALIGN_M;
            d.stage_v   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.sp        <= DW'(SP_RESET) & ALIGN_M;
        end else begin
            q <= d;
        end
    end

    assign mem_we    = q.we;
    assign mem_re    = q.re;
    assign mem_addr  = q.addr;
    assign mem_wdata = q.wdata;
    assign sp_out    = q.sp;
    assign busy      = q.phase;
    assign trap      = q.trap;
endmodule

// File: rtl/stk_sp_chk.sv
module stk_sp_chk #(
    parameter int DW    = 16,
    parameter int FLOOR = 16'h0800
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_we,
    input logic          mem_re,
    input logic [DW-1:0] mem_addr,
    input logic [DW-1:0] sp_out,
    input logic          busy,
    input logic          trap
);
    assert_sp_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sp_out[0]);

    assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (sp_out == mem_addr + DW'(2)));

    assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> (sp_out == mem_addr));

    assert_floor_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> (mem_addr >= DW'(FLOOR)));

    assert_trap_no_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (!mem_we && !mem_re));

    assert_trap_sp_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> $stable(sp_out));

    assert_busy_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> mem_we);

    assert_busy_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
endmodule

bind stkptr_unit stk_sp_chk #(.DW(DW), .FLOOR(FLOOR)) u_sp_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .mem_addr (mem_addr),
    .sp_out   (sp_out),
    .busy     (busy),
    .trap     (trap)
);

// File: tb/sim_stkptr_unit.sv
`timescale 1ns/1ps
module sim_stkptr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_req = 0, pop_req = 0, call_req = 0, exc_req = 0, lim_we = 0;
    logic [15:0] push_data = '0, lim_wdata = '0;
    logic [22:0] pc_in = '0;
    logic [7:0]  status_in = '0;
    logic        mem_we, mem_re, busy, trap;
    logic [15:0] mem_addr, mem_wdata, sp_out;

    int checks = 0;
    int failures = 0;

    // behavioural reference state
    int m_sp = 'h0800, m_lim = 0, m_stage = 0, m_upper = 0;
    bit m_lon = 0, m_sv = 0, m_phase = 0;

    always #5 clk = ~clk;

    stkptr_unit u0 (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
        .call_req(call_req), .exc_req(exc_req), .push_data(push_data),
        .pc_in(pc_in), .status_in(status_in), .lim_we(lim_we),
        .lim_wdata(lim_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .sp_out(sp_out),
        .busy(busy), .trap(trap)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++;
        failures++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
    end

    task automatic step(bit pu, bit po, bit ca, bit ex, int dat, int pc, int st,
                        bit lwe, int lwd, string tag);
        int  a, kind, e_addr, e_wd;
        bit  bad, e_we, e_re, e_trap;
        @(negedge clk);
        push_req = pu; pop_req = po; call_req = ca; exc_req = ex;
        push_data = dat[15:0]; pc_in = pc[22:0]; status_in = st[7:0];
        lim_we = lwe; lim_wdata = lwd[15:0];
        @(posedge clk);
        #1;
        // model: precedence upper word, exception, call, push, pop
        kind = 0;
        if (m_phase) kind = 5;
        else if (ex) kind = 4;
        else if (ca) kind = 3;
        else if (pu) kind = 1;
        else if (po) kind = 2;
        a = (kind == 2) ? ((m_sp - 2) & 'hFFFF) : m_sp;
        bad = (a < 'h0800) || (m_lon && a > m_lim);
        e_we = 0; e_re = 0; e_trap = 0; e_addr = 0; e_wd = 0;
        m_phase = 0;
        if (kind != 0) begin
            if (bad) e_trap = 1;
            else begin
                e_addr = a;
                case (kind)
                    1: begin e_we = 1; e_wd = dat & 'hFFFF; m_sp = (m_sp + 2) & 'hFFFF; end
                    2: begin e_re = 1; m_sp = a; end
                    3, 4: begin
                        e_we = 1; e_wd = pc & 'hFFFF; m_sp = (m_sp + 2) & 'hFFFF;
                        m_phase = 1;
                        m_upper = (pc >> 16) & 'h7F;
                        if (kind == 4) m_upper = m_upper | ((st & 'hFF) << 8);
                    end
                    default: begin e_we = 1; e_wd = m_upper; m_sp = (m_sp + 2) & 'hFFFF; end
                endcase
            end
        end
        if (m_sv) begin m_lim = m_stage; m_lon = 1; m_sv = 0; end
        if (lwe) begin m_stage = lwd & 'hFFFE; m_sv = 1; end
        checks++;
        if (mem_we !== e_we || mem_re !== e_re || trap !== e_trap || busy !== m_phase ||
            sp_out !== m_sp[15:0] || ((e_we || e_re) && mem_addr !== e_addr[15:0]) ||
            (e_we && mem_wdata !== e_wd[15:0])) begin
            failures++;
            $display("FAIL %s: actual we=%0b re=%0b trap=%0b busy=%0b sp=%h addr=%h wd=%h expected we=%0b re=%0b trap=%0b busy=%0b sp=%h addr=%h wd=%h",
                     tag, mem_we, mem_re, trap, busy, sp_out, mem_addr, mem_wdata,
                     e_we, e_re, e_trap, m_phase, m_sp[15:0], e_addr[15:0], e_wd[15:0]);
        end
    endtask

    task automatic push(int d, string tag);      step(1,0,0,0,d,0,0,0,0,tag); endtask
    task automatic pop(string tag);               step(0,1,0,0,0,0,0,0,0,tag); endtask
    task automatic idle(string tag);              step(0,0,0,0,0,0,0,0,0,tag); endtask
    task automatic setlim(int v, string tag);     step(0,0,0,0,0,0,0,1,v,tag); endtask
    task automatic call(int pc, string tag);      step(0,0,1,0,0,pc,0,0,0,tag); endtask
    task automatic exc(int pc, int st, string tag); step(0,0,0,1,0,pc,st,0,0,tag); endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (sp_out !== 16'h0800 || trap !== 0 || busy !== 0 || mem_we !== 0 || mem_re !== 0) begin
            failures++;
            $display("FAIL R1: actual sp=%h trap=%0b busy=%0b we=%0b re=%0b expected sp=0800 all low",
                     sp_out, trap, busy, mem_we, mem_re);
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1 idle after reset");
        pop("R6 pop at floor traps");
        pop("R7 second underflow pulse");
        for (int i = 0; i < 6; i++) push('hA000 + i, "R2 R12 push without bound");
        for (int i = 0; i < 2; i++) pop("R3 pop");
        // pointer 0x0808; bound write 0x0805 lands as 0x0804, two cycles late
        setlim('h0805, "R4 R8 bound write");
        push('hB001, "R8 push right after write uses old bound");
        push('hB002, "R5 R8 new bound traps");
        push('hB003, "R7 repeated trap keeps pointer");
        for (int i = 0; i < 3; i++) pop("R3 pop under bound");
        push('hC000, "R5 push at bound accepted");
        push('hC001, "R5 push above bound traps");
        pop("R3 pop back");
        step(1,0,0,0,'hD000,0,0,1,'h0900,"R8 push in write cycle uses old bound");
        idle("R8 settle");
        call('h5A1234, "R9 call first word");
        push('hEEEE, "R9 request ignored while busy");
        exc('h7F0042, 'hC3, "R10 exception frame");
        idle("R10 second word");
        step(1,1,0,0,'h1111,0,0,0,0,"R11 push beats pop");
        step(1,0,1,0,'h2222,'h012345,0,0,0,"R11 call beats push");
        idle("R11 frame tail");
        step(0,0,1,1,0,'h4ABCDE,'h5A,0,0,"R11 exception beats call");
        idle("R11 frame tail");
        // second word crosses the bound
        setlim(sp_out, "R13 bound at pointer");
        idle("R13 settle");
        call('h000111, "R13 first word at bound");
        idle("R13 second word traps");
        call('h000222, "R13 first word traps");
        idle("R13 busy stays low");
        setlim('h0900, "R8 widen bound");
        idle("R8 settle");
        for (int i = 0; i < 400; i++) begin
            int r = $urandom_range(0, 15);
            int lv = 'h07F0 + $urandom_range(0, 'h60);
            step(r < 5, r >= 4 && r < 10, r == 10, r == 11, $urandom, $urandom, $urandom,
                 r >= 13, lv, "R11 R5 R6 randomized");
        end
        summary();
    end
endmodule